// File: doc/BRIEF.md
# Edge-Armed Manchester Bit Sampler

This block recovers data bits from a squared envelope signal produced by a 125 kHz near-field tag reader. The tag sends Manchester code. Each bit has one transition in its middle: a rising edge means 1 and a falling edge means 0. The bit period is 64 carrier cycles, which is 512 µs. The comparator that squares the envelope sits outside this block, and so does the frame parser that consumes the bits.

The block waits for a transition of either polarity on its resynchronised input line. A transition starts a one-shot delay of three quarters of a bit period. While that delay runs, the block does not look at the line, so the transitions at bit boundaries are skipped. When the delay expires, the block latches the line level onto `bit_out` and pulses `bit_valid` for one clock. It then waits for the next transition. The delay is a parameter given in clock cycles. The default of 3072 suits an 8 MHz clock (64 × 48 ticks = 384 µs).

Top module: `mbit_sampler`

## Requirements
- R1: A synchronous active-high `rst` drives `bit_out` and `bit_valid` to 0 and cancels any pending sample. The block then waits for a new transition, and no strobe appears until one arrives after reset is released.
- R2: `line_in` passes through a two-flop synchroniser. Let k be the rising clock edge that first captures a change. `bit_valid` is then high in the cycle that follows rising edge k + DELAY_CYCLES + 2.
- R3: A rising transition and a falling transition each start the delay timer.
- R4: While the timer runs, transitions on `line_in` neither restart the timer nor produce extra strobes. Exactly one strobe follows the transition that started the timer.
- R5: The value on `bit_out` at a strobe is the `line_in` level as captured at rising edge k + DELAY_CYCLES, even when the line toggled earlier in the delay.
- R6: `bit_valid` is high for exactly one clock per sample. `bit_out` holds its value between strobes.
- R7: After a strobe, only a transition that occurs after that strobe starts a new delay. A level change left behind by transitions that arrived during the delay does not start one. The first transition after the strobe produces a new strobe with the new level.
- R8: Take DELAY_CYCLES equal to three quarters of the bit period, and a stream of N Manchester bits (1 = low then high, 0 = high then low) that starts with a 1 from a low idle line. The block then gives exactly N strobes. Strobe k carries the first-half level of bit k+1, and the last strobe carries the final line level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| line_in | input | 1 | Asynchronous squared envelope line |
| bit_out | output | 1 | Line level latched at the last sample |
| bit_valid | output | 1 | One-clock strobe marking a new sample |

## Verification
The bench builds the block with DELAY_CYCLES = 12 and a 16-cycle bit period. At that size the three-quarter-period lock-out, the boundary transitions it swallows, and a full ten-bit Manchester stream all fit in a few hundred cycles. The short delay also lets directed cases place glitches, a mid-delay reset and a re-arming edge at exact cycle offsets inside the delay window. Each of these cases checks an exact latency of DELAY_CYCLES + 3 observed cycles.

// File: rtl/sampler_pkg.sv
package sampler_pkg;

  // Sampler phase: waiting for a transition, or timing the lock-out window
  typedef enum logic {
    PH_ARMED  = 1'b0,
    PH_TIMING = 1'b1
  } phase_t;

  // Counter width that can hold values 0 .. n-1 (at least one bit)
  function automatic int count_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/sampler_sync.sv
module sampler_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= 1'b0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/sampler_edge.sv
module sampler_edge (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic enable,
  output logic level_prev,
  output logic edge_hit
);

  // History follows the line on every cycle, so only transitions that
  // happen while enabled are reported.
  always_ff @(posedge clk) begin
    if (rst) level_prev <= 1'b0;
    else     level_prev <= level;
  end

  assign edge_hit = enable & (level ^ level_prev);

endmodule

// File: rtl/sampler_delay.sv
module sampler_delay
  import sampler_pkg::*;
#(
  parameter int DELAY_CYCLES = 3072,
  parameter int CNT_W        = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic             expire,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYCLES - 1);

  phase_t phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_ARMED;
      count <= '0;
    end else begin
      case (phase)
        PH_ARMED: begin
          count <= '0;
          if (start) phase <= PH_TIMING;
        end
        PH_TIMING: begin
          if (count == LAST) begin
            phase <= PH_ARMED;
            count <= '0;
          end else begin
            count <= count + 1'b1;
          end
        end
        default: begin
          phase <= PH_ARMED;
          count <= '0;
        end
      endcase
    end
  end

  assign busy   = (phase == PH_TIMING);
  assign expire = busy && (count == LAST);

endmodule

// File: rtl/mbit_sampler.sv
module mbit_sampler
  import sampler_pkg::*;
#(
  parameter int DELAY_CYCLES = 3072,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic bit_out,
  output logic bit_valid
);

  localparam int CNT_W = count_width(DELAY_CYCLES);

  logic             line_sync;
  logic             line_prev;
  logic             edge_hit;
  logic             busy;
  logic             expire;
  logic [CNT_W-1:0] tcount;

  sampler_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (line_in),
    .q   (line_sync)
  );

  sampler_edge u_edge (
    .clk        (clk),
    .rst        (rst),
    .level      (line_sync),
    .enable     (~busy),
    .level_prev (line_prev),
    .edge_hit   (edge_hit)
  );

  sampler_delay #(
    .DELAY_CYCLES (DELAY_CYCLES),
    .CNT_W        (CNT_W)
  ) u_delay (
    .clk    (clk),
    .rst    (rst),
    .start  (edge_hit),
    .busy   (busy),
    .expire (expire),
    .count  (tcount)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_out   <= 1'b0;
      bit_valid <= 1'b0;
    end else begin
      bit_valid <= expire;
      if (expire) bit_out <= line_sync;
    end
  end

endmodule

// File: rtl/mbit_sampler_props.sv
module mbit_sampler_props #(
  parameter int DELAY_CYCLES = 3072,
  parameter int CNT_W        = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             line_sync,
  input logic             line_prev,
  input logic             busy,
  input logic [CNT_W-1:0] tcount,
  input logic             bit_out,
  input logic             bit_valid
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYCLES - 1);

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: first cycle after reset shows cleared outputs and an idle timer
  always @(posedge clk) begin
    if (!rst && rst_d) begin
      assert_reset_clear_R1: assert (!bit_valid && !bit_out && !busy)
        else $error("reset did not clear sampler");
    end
  end

  // R3: any transition seen while idle starts the timer
  assert_edge_arms_R3: assert property (@(posedge clk) disable iff (rst)
    (!busy && (line_sync != line_prev)) |=> busy);

  // R4: the timer keeps running until its last count
  assert_lockout_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && (tcount != LAST)) |=> busy);

  // R5: the strobed bit is the synchronised level at expiry
  assert_bit_level_R5: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> (bit_out == $past(line_sync)));

  // R6: strobe lasts one cycle
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> !bit_valid);

  // R6: a strobe only follows a timing window
  assert_strobe_after_timing_R6: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> $past(busy));

  // R6: bit_out holds between strobes
  assert_bit_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |-> $stable(bit_out));

endmodule

bind mbit_sampler mbit_sampler_props #(
  .DELAY_CYCLES (DELAY_CYCLES),
  .CNT_W        (CNT_W)
) u_props (
  .clk       (clk),
  .rst       (rst),
  .line_sync (line_sync),
  .line_prev (line_prev),
  .busy      (busy),
  .tcount    (tcount),
  .bit_out   (bit_out),
  .bit_valid (bit_valid)
);

// File: tb/mbit_sampler_bench.sv
`timescale 1ns/1ps
module mbit_sampler_bench;

  localparam int D    = 12;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_in = 1'b0;
  logic bit_out;
  logic bit_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit cmp_on = 1'b0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  mbit_sampler #(
    .DELAY_CYCLES (D),
    .SYNC_STAGES  (2)
  ) u_mbit_sampler (
    .clk       (clk),
    .rst       (rst),
    .line_in   (line_in),
    .bit_out   (bit_out),
    .bit_valid (bit_valid)
  );

  // Behavioural reference: history of captured line values plus a countdown
  bit hist[$] = '{0, 0, 0, 0};
  bit armed = 1'b1;
  int left = 0;
  bit exp_valid = 1'b0;
  bit exp_bit = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      hist = '{0, 0, 0, 0};
      armed = 1'b1;
      left = 0;
      exp_valid = 1'b0;
      exp_bit = 1'b0;
    end else begin
      hist.push_front(bit'(line_in));
      void'(hist.pop_back());
      exp_valid = 1'b0;
      if (!armed) begin
        left--;
        if (left == 0) begin
          exp_valid = 1'b1;
          exp_bit = hist[2];
          armed = 1'b1;
        end
      end else if (hist[2] != hist[3]) begin
        armed = 1'b0;
        left = D;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int actual, input int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  // Per-cycle comparison against the reference, plus strobe capture
  int strobe_cnt = 0;
  bit got_bits[$];

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      check(bit_valid == exp_valid, cur_req, "bit_valid vs model", bit_valid, exp_valid);
      check(bit_out == exp_bit, cur_req, "bit_out vs model", bit_out, exp_bit);
      if (bit_valid) begin
        strobe_cnt++;
        got_bits.push_back(bit_out);
      end
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic set_line(input logic v);
    @(negedge clk);
    line_in = v;
  endtask

  task automatic print_summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic latency_case(input logic lvl, input string req);
    int n = 0;
    bit seen = 1'b0;
    bit val = 1'b0;
    cur_req = req;
    set_line(lvl);
    for (int i = 1; i <= 3 * D; i++) begin
      @(negedge clk);
      if (bit_valid && !seen) begin
        seen = 1'b1;
        n = i;
        val = bit_out;
      end
    end
    check(n == D + 3, req, "strobe latency", n, D + 3);
    check(val == lvl, "R5", "strobed level", val, lvl);
  endtask

  initial begin
    int s;
    int pat[10] = '{1, 0, 0, 1, 1, 1, 0, 1, 0, 0};
    bit expb[10];

    // R1: outputs cleared under reset
    repeat (3) @(negedge clk);
    check(bit_valid == 1'b0, "R1", "bit_valid in reset", bit_valid, 0);
    check(bit_out == 1'b0, "R1", "bit_out in reset", bit_out, 0);
    rst = 1'b0;
    cmp_on = 1'b1;
    wait_cycles(4);

    // R2 / R3: rising edge latency, then falling edge
    latency_case(1'b1, "R2");
    latency_case(1'b0, "R3");

    // R4: glitches inside the window, line ends where it started
    cur_req = "R4";
    s = strobe_cnt;
    set_line(1'b1); wait_cycles(4);
    set_line(1'b0); wait_cycles(2);
    set_line(1'b1); wait_cycles(2);
    set_line(1'b0);
    wait_cycles(3 * D);
    check(strobe_cnt - s == 1, "R4", "strobes for glitchy window", strobe_cnt - s, 1);
    check(got_bits[got_bits.size()-1] == 1'b0, "R5", "level at expiry", got_bits[got_bits.size()-1], 0);

    // R7: line left changed by edges inside the window gives no new strobe
    cur_req = "R7";
    s = strobe_cnt;
    set_line(1'b1); wait_cycles(4);
    set_line(1'b0); wait_cycles(2);
    set_line(1'b1);
    wait_cycles(3 * D);
    check(strobe_cnt - s == 1, "R7", "strobes after changed level", strobe_cnt - s, 1);
    check(bit_out == 1'b1, "R6", "bit_out held after strobe", bit_out, 1);

    // R1: reset in mid window cancels the sample and clears bit_out
    cur_req = "R1";
    s = strobe_cnt;
    set_line(1'b0);
    wait_cycles(D / 2);
    rst = 1'b1;
    wait_cycles(2);
    check(bit_out == 1'b0, "R1", "bit_out cleared by reset", bit_out, 0);
    check(bit_valid == 1'b0, "R1", "bit_valid cleared by reset", bit_valid, 0);
    @(negedge clk);
    rst = 1'b0;
    wait_cycles(3 * D);
    check(strobe_cnt == s, "R1", "strobes after aborted window", strobe_cnt - s, 0);

    // R7: a fresh transition after idle re-arms the sampler
    latency_case(1'b1, "R7");
    set_line(1'b0);
    wait_cycles(3 * D);

    // R8: ten-bit Manchester stream from a low idle line
    cur_req = "R8";
    s = strobe_cnt;
    got_bits.delete();
    for (int k = 0; k < 10; k++) begin
      expb[k] = (k < 9) ? ((pat[k+1] == 1) ? 1'b0 : 1'b1) : bit'(pat[9]);
    end
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      line_in = (pat[k] == 1) ? 1'b0 : 1'b1;
      repeat (HALF - 1) @(negedge clk);
      @(negedge clk);
      line_in = (pat[k] == 1) ? 1'b1 : 1'b0;
      repeat (HALF - 1) @(negedge clk);
    end
    wait_cycles(3 * D);
    check(strobe_cnt - s == 10, "R8", "strobes for ten bits", strobe_cnt - s, 10);
    for (int k = 0; k < 10; k++) begin
      if (k < got_bits.size())
        check(got_bits[k] == expb[k], "R8", $sformatf("stream bit %0d", k), got_bits[k], expb[k]);
      else
        check(1'b0, "R8", $sformatf("stream bit %0d missing", k), 0, expb[k]);
    end

    done = 1'b1;
    print_summary();
    $finish;
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      print_summary();
      $finish;
    end
  end

endmodule